// File: doc/BRIEF.md
# NAND Read-Retry Mode Programmer

This block moves a raw NAND device into one of several read-retry modes. A caller supplies a mode index. The block then opens the device's private parameter-set session with a command cycle. It writes a fixed list of private registers, each as an address cycle carrying the register offset followed by a data cycle carrying the value. It closes with an apply command. The values come from a small internal mode-by-register table, which the surrounding logic fills beforehand through a plain write port. The surrounding logic also presents the number of modes the table holds.

Each bus cycle goes to a downstream bus-cycle engine as a valid/ready stream beat. The block raises `bus_valid` with a kind and a byte. It holds both unchanged while `bus_ready` is low, so the engine may stall for any number of cycles. The beat is consumed in the cycle where both signals are high. In that same cycle the engine reports the outcome on `bus_fail`. A failure ends the sequence at once, and no further cycles are issued. The caller side uses plain pins. A request pulse with a mode is taken only while the block is idle. A one-cycle `done` marks the end of every request, and `err` is valid alongside it.

Top module: `nand_rr_prog`

## Requirements
- R1: The first beat of an accepted request is a command beat (kind code 0) carrying byte 0x36.
- R2: After the open command, one address beat (kind code 1) and then one data beat (kind code 2) are issued for each register. The offsets go out in the order 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF.
- R3: The data beat for register j in mode m carries the table entry at index m*NUM_REGS + j, the same index the table write port uses.
- R4: The last beat is a command beat with byte 0x16. A full sequence therefore has 2 + 2*NUM_REGS beats. After it is accepted, `done` pulses with `err` low in the next cycle.
- R5: A request whose mode is greater than or equal to `mode_count` causes no beat at all. `done` and `err` pulse together in the next cycle.
- R6: While `bus_valid` is high and `bus_ready` is low, the beat's kind and byte stay unchanged and `bus_valid` stays high.
- R7: If `bus_fail` is high in an accepting cycle, no further beat is issued and the apply command is skipped if not yet sent. `done` and `err` pulse together in the next cycle.
- R8: After reset, `busy`, `bus_valid`, `done` and `err` are low.
- R9: A request raised while the block is busy is ignored.
- R10: `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 6 | Table write index (mode*NUM_REGS + reg) |
| tbl_wdata | input | 8 | Table write value |
| mode_count | input | 4 | Number of valid modes in the table |
| req | input | 1 | Request strobe, taken only when idle |
| req_mode | input | 3 | Requested retry mode |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Error flag, valid with done |
| bus_valid | output | 1 | Beat offered to the engine |
| bus_ready | input | 1 | Engine accepts the beat |
| bus_kind | output | 2 | 0 command, 1 address, 2 data |
| bus_byte | output | 8 | Beat byte |
| bus_fail | input | 1 | Engine reports failure of the accepted beat |

## Verification
Sequences are run for the lowest, middle and highest valid modes. This tells apart table indexing errors, because each mode row holds distinct values. Each sequence runs with no back-pressure, with every-other-cycle stalls and with two-in-three stalls. These separate correct beat holding from beats that are lost or repeated. Failures are injected on the open command, on a mid-sequence data beat and on the apply command, which shows that no beat follows an abort. Out-of-range modes at the boundary and a request raised while busy check that the caller side rejects and ignores correctly.

// File: rtl/nrr_pkg.sv
package nrr_pkg;

  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_DATA = 2'd2
  } bus_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_ADDR,
    ST_DATA,
    ST_APPLY
  } seq_state_e;

  localparam logic [7:0] CMD_OPEN  = 8'h36;
  localparam logic [7:0] CMD_APPLY = 8'h16;
  localparam int unsigned OFFSET_LIST_LEN = 8;

  // Private register offsets, in the order the device expects them.
  function automatic logic [7:0] reg_offset(input int unsigned idx);
    case (idx)
      0:       return 8'hCC;
      1:       return 8'hBF;
      2:       return 8'hAA;
      3:       return 8'hAB;
      4:       return 8'hCD;
      5:       return 8'hAD;
      6:       return 8'hAE;
      default: return 8'hAF;
    endcase
  endfunction

endpackage

// File: rtl/nrr_table.sv
module nrr_table #(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned MAX_MODES = 8,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned DEPTH    = NUM_REGS * MAX_MODES,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/nrr_seq.sv
module nrr_seq
  import nrr_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned MAX_MODES = 8,
  localparam int unsigned MODE_W   = $clog2(MAX_MODES),
  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned AW       = $clog2(NUM_REGS * MAX_MODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [MODE_W:0]   mode_count,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [AW-1:0]     tbl_raddr,
  input  logic [7:0]        tbl_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [1:0]        bus_kind,
  output logic [7:0]        bus_byte,
  input  logic              bus_fail
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  seq_state_e        state_q;
  logic [MODE_W-1:0] mode_q;
  logic [IDX_W-1:0]  idx_q;
  logic              mode_bad;
  logic              beat_taken;

  assign mode_bad   = {1'b0, req_mode} >= mode_count;
  assign beat_taken = bus_valid && bus_ready;
  assign tbl_raddr  = AW'(mode_q) * AW'(NUM_REGS) + AW'(idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      idx_q   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (req) begin
          if (mode_bad) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            mode_q  <= req_mode;
            idx_q   <= '0;
            state_q <= ST_OPEN;
          end
        end
      end else if (beat_taken) begin
        if (bus_fail) begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
          err     <= 1'b1;
        end else begin
          case (state_q)
            ST_OPEN:  state_q <= ST_ADDR;
            ST_ADDR:  state_q <= ST_DATA;
            ST_DATA: begin
              if (idx_q == LAST_IDX) begin
                state_q <= ST_APPLY;
              end else begin
                idx_q   <= idx_q + 1'b1;
                state_q <= ST_ADDR;
              end
            end
            default: begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    bus_kind = BK_CMD;
    bus_byte = CMD_OPEN;
    case (state_q)
      ST_ADDR: begin
        bus_kind = BK_ADDR;
        bus_byte = reg_offset(32'(idx_q));
      end
      ST_DATA: begin
        bus_kind = BK_DATA;
        bus_byte = tbl_rdata;
      end
      ST_APPLY: bus_byte = CMD_APPLY;
      default: ;
    endcase
  end

  assign bus_valid = (state_q != ST_IDLE);
  assign busy      = bus_valid;

  a_r1_open_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_kind == BK_CMD && bus_byte == CMD_OPEN));

  a_r2_addr_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_taken && !bus_fail && bus_kind == BK_ADDR) |=> (bus_valid && bus_kind == BK_DATA));

  a_r5_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req && mode_bad) |=> (!bus_valid && done && err));

  a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_kind) && $stable(bus_byte)));

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_taken && bus_fail) |=> (!bus_valid && done && err));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/nand_rr_prog.sv
module nand_rr_prog #(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned MAX_MODES = 8,
  localparam int unsigned MODE_W   = $clog2(MAX_MODES),
  localparam int unsigned AW       = $clog2(NUM_REGS * MAX_MODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_waddr,
  input  logic [7:0]        tbl_wdata,
  input  logic [MODE_W:0]   mode_count,
  input  logic              req,
  input  logic [MODE_W-1:0] req_mode,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [1:0]        bus_kind,
  output logic [7:0]        bus_byte,
  input  logic              bus_fail
);

  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  nrr_table #(
    .NUM_REGS  (NUM_REGS),
    .MAX_MODES (MAX_MODES),
    .DATA_W    (8)
  ) table_i (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  nrr_seq #(
    .NUM_REGS  (NUM_REGS),
    .MAX_MODES (MAX_MODES)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_mode   (req_mode),
    .mode_count (mode_count),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .tbl_raddr  (rd_addr),
    .tbl_rdata  (rd_data),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_kind   (bus_kind),
    .bus_byte   (bus_byte),
    .bus_fail   (bus_fail)
  );

  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!busy && !bus_valid && !done && !err));

endmodule

// File: tb/nand_rr_prog_tb_top.sv
module nand_rr_prog_tb_top;

  localparam int NR = 8;
  localparam int NBEATS = 2 + 2 * NR;
  localparam int NVEC = 7;
  // {mode[3:0], stall[1:0], poke[0], fail[7:0]} ; fail 8'hFF = none
  localparam logic [14:0] VECS [NVEC] = '{
    {4'd0, 2'd0, 1'b0, 8'hFF},
    {4'd5, 2'd1, 1'b0, 8'hFF},
    {4'd3, 2'd2, 1'b1, 8'hFF},
    {4'd2, 2'd0, 1'b0, 8'd0},
    {4'd4, 2'd1, 1'b0, 8'd6},
    {4'd1, 2'd2, 1'b0, 8'd17},
    {4'd5, 2'd0, 1'b0, 8'd9}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic tbl_we = 0;
  logic [5:0] tbl_waddr = '0;
  logic [7:0] tbl_wdata = '0;
  logic [3:0] mode_count = 4'd6;
  logic req = 0;
  logic [2:0] req_mode = '0;
  logic busy, done, err, bus_valid;
  logic bus_ready = 0;
  logic [1:0] bus_kind;
  logic [7:0] bus_byte;
  logic bus_fail = 0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nand_rr_prog dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .mode_count(mode_count), .req(req),
    .req_mode(req_mode), .busy(busy), .done(done), .err(err),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_kind(bus_kind),
    .bus_byte(bus_byte), .bus_fail(bus_fail)
  );

  function automatic logic [7:0] tval(int m, int j);
    return 8'((m * 37 + j * 11) ^ 8'hA5);
  endfunction

  function automatic logic [7:0] offs(int j);
    logic [7:0] lst [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
    return lst[j];
  endfunction

  function automatic logic [9:0] exp_beat(int m, int i); // {kind, byte}
    if (i == 0) return {2'd0, 8'h36};
    if (i == NBEATS - 1) return {2'd0, 8'h16};
    if (i % 2 == 1) return {2'd1, offs((i - 1) / 2)};
    return {2'd2, tval(m, (i - 1) / 2)};
  endfunction

  task automatic check(input logic ok, input string req_tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, expv, $time);
    end
  endtask

  task automatic run_vec(input int m, input int stall, input bit poke, input int fail_at);
    int n = 0;
    int cyc = 0;
    bit held = 0;
    logic [9:0] held_beat = '0;
    int exp_n;
    req_mode = 3'(m);
    req = 1;
    @(negedge clk);
    req = 0;
    check(busy == 1'b1, "R1 busy after request", busy, 1);
    forever begin
      if (done) break;
      if (cyc > 200) begin
        check(1'b0, "R4 sequence did not end", cyc, 0);
        break;
      end
      if (poke && cyc == 2) begin
        req = 1;
        req_mode = 3'd7;
      end else begin
        req = 0;
      end
      if (held) begin
        check(bus_valid && {bus_kind, bus_byte} == held_beat, "R6 beat held under stall",
              {bus_kind, bus_byte}, held_beat);
        held = 0;
      end
      if (bus_valid) begin
        case (stall)
          1: bus_ready = cyc[0];
          2: bus_ready = (cyc % 3 == 2);
          default: bus_ready = 1;
        endcase
        if (bus_ready) begin
          check({bus_kind, bus_byte} == exp_beat(m, n),
                (n % 2 == 0 && n > 0 && n < NBEATS - 1) ? "R3 data value" :
                (n % 2 == 1 && n < NBEATS - 1) ? "R2 address beat" :
                (n == 0) ? "R1 open command" : "R4 apply command",
                {bus_kind, bus_byte}, exp_beat(m, n));
          bus_fail = (n == fail_at);
          n++;
        end else begin
          bus_fail = 0;
          held = 1;
          held_beat = {bus_kind, bus_byte};
        end
      end else begin
        bus_ready = 0;
        bus_fail = 0;
      end
      @(negedge clk);
      cyc++;
    end
    req = 0;
    bus_ready = 0;
    bus_fail = 0;
    exp_n = (fail_at >= 0 && fail_at < NBEATS) ? fail_at + 1 : NBEATS;
    check(n == exp_n, (fail_at >= 0) ? "R7 beats before abort" : "R4 beat count", n, exp_n);
    check(err == (fail_at >= 0), (fail_at >= 0) ? "R7 err on abort" : "R4 err low",
          err, (fail_at >= 0));
    check(!bus_valid, "R7 no beat after end", bus_valid, 0);
    @(negedge clk);
    check(!done && !bus_valid, "R10 done single cycle", done, 0);
    if (poke) check(!busy, "R9 busy request ignored", busy, 0);
  endtask

  initial begin
    #1ms;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !bus_valid && !done && !err, "R8 reset state",
          {busy, bus_valid, done, err}, 0);
    rst_n = 1;
    for (int m = 0; m < 8; m++) begin
      for (int j = 0; j < NR; j++) begin
        tbl_we = 1;
        tbl_waddr = 6'(m * NR + j);
        tbl_wdata = tval(m, j);
        @(negedge clk);
      end
    end
    tbl_we = 0;
    check(!busy && !done, "R8 idle after reset", busy, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_vec(int'(VECS[v][14:11]), int'(VECS[v][10:9]), VECS[v][8],
              (VECS[v][7:0] == 8'hFF) ? -1 : int'(VECS[v][7:0]));
      @(negedge clk);
    end

    // R5: out-of-range modes, at and above the boundary
    for (int k = 6; k < 8; k++) begin
      req_mode = 3'(k);
      req = 1;
      @(negedge clk);
      req = 0;
      check(done && err && !bus_valid, "R5 reject out-of-range mode",
            {done, err, bus_valid}, 3'b110);
      @(negedge clk);
      check(!bus_valid && !busy && !done, "R5 no bus activity after reject",
            {bus_valid, busy, done}, 0);
    end

    // R5: mode_count lowered makes a formerly valid mode illegal
    mode_count = 4'd2;
    req_mode = 3'd2;
    req = 1;
    @(negedge clk);
    req = 0;
    check(done && err && !bus_valid, "R5 reject at mode_count boundary",
          {done, err, bus_valid}, 3'b110);
    mode_count = 4'd8;
    @(negedge clk);
    run_vec(7, 0, 1'b0, -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule